// File: doc/BRIEF.md
# Control Bus Register Access Slave

This block is the drive side of an asynchronous, multi-drop register transfer handshake. A controller shared by several drives sets up a drive address, a register number, sixteen data bits with an odd parity bit, and a direction flag, then raises a demand strobe. The demand strobe is brought into the local clock domain through a synchronizer. Only the drive whose strapped unit number matches the address takes part. That drive runs a fixed-length pulse that is counted in system clocks, followed by a short settling gap, and then raises a transfer acknowledge. The acknowledge stays high until the controller drops demand.

At the leading edge of the pulse the drive latches its errors and commits the write. It flags bad parity, a register number outside the implemented range, and any attempt to modify a register while an operation is running. A write is dropped when the register is illegal or when the modification is refused. A write to the control register that arrives with a parity error still stores the data, but it never sets the GO bit. Reads drive the selected register onto the return lines together with a freshly generated odd parity bit. The registers themselves are a simple stub array: register 0 holds GO in bit 0, and register 2 is a view of the error flags.

Top module: `cbus_reg_slave`

## Requirements
- R1: A transfer whose 3-bit drive address differs from `unit_addr` produces no acknowledge and no read drive, and it leaves the stored registers unchanged.
- R2: When GO is clear, a write to any implemented register other than 2 stores all 16 data bits. A later read of that register returns them.
- R3: During a read, `ctl_oe` is high and `ctl_out` carries the register contents. `ctl_par_out` makes the 17 bits `{ctl_out, ctl_par_out}` contain an odd number of ones.
- R4: On a write whose parity bit does not give odd parity over data plus parity, `err_par` is set. The data is still stored.
- R5: Register numbers from NUM_REGS (default 12) to 31 are illegal. A write to one sets `err_ilr` and stores nothing. A read of one sets `err_ilr` and returns zero.
- R6: While GO is set, writes to registers 3 and 4 are accepted. Writes to every other implemented register, register 2 included, are refused: `err_rmr` is set and the register keeps its value.
- R7: A write to register 0 with a parity error never sets GO. Bit 0 is stored as 0.
- R8: The acknowledge `tra` rises exactly 3 + PULSE_CYC + GAP_CYC rising clock edges after demand goes high. The internal pulse lasts exactly PULSE_CYC cycles.
- R9: `tra` stays high while demand is high. It falls on the third rising edge after demand goes low.
- R10: An accepted write to register 2 clears all three error flags. A read of register 2 returns `err_rmr` in bit 2, `err_ilr` in bit 1 and `err_par` in bit 0, with all other bits zero.
- R11: A one-cycle `op_done` pulse clears GO on the next rising edge.
- R12: After reset, `tra`, `ctl_oe`, `go` and all error flags are 0, and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_addr | input | 3 | Strapped unit number of this drive |
| dsel | input | 3 | Drive address from the controller |
| rsel | input | 5 | Register number from the controller |
| ctl_in | input | 16 | Write data from the controller |
| ctl_par_in | input | 1 | Odd parity bit for `ctl_in` |
| to_drive | input | 1 | 1 = write to drive, 0 = read from drive |
| demand | input | 1 | Asynchronous demand strobe |
| op_done | input | 1 | Running operation finished; clears GO |
| ctl_out | output | 16 | Read data returned to the controller |
| ctl_par_out | output | 1 | Odd parity bit for `ctl_out` |
| ctl_oe | output | 1 | Read data is being driven |
| tra | output | 1 | Transfer acknowledge |
| go | output | 1 | GO bit of register 0 |
| err_par | output | 1 | Control-bus parity error flag |
| err_ilr | output | 1 | Illegal register flag |
| err_rmr | output | 1 | Register modification refused flag |

## Verification
The hardest case to reach is a refused modification. A refusal needs GO to be set first, and GO is only set by a clean write to register 0. The stimulus therefore first shows that a register 0 write with bad parity leaves GO clear. It then clears the error flags, sets GO with a clean write, and, with GO still running, tries to write an ordinary register and also tries to clear the error register itself. Both attempts must be refused. Only after that does `op_done` end the operation, and the error register is cleared for real.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int DATA_W = 16;
  localparam int DSEL_W = 3;
  localparam int RSEL_W = 5;
  localparam int ERR_IDX = 2;
  localparam int CTRL_IDX = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_GAP, ST_ACK} seq_st_t;

  // parity bit that makes data plus bit hold an odd number of ones
  function automatic logic odd_par(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  function automatic logic reg_exists(input logic [RSEL_W-1:0] s, input int n);
    return int'(s) < n;
  endfunction

  function automatic logic open_while_busy(input logic [RSEL_W-1:0] s);
    return (s == RSEL_W'(3)) || (s == RSEL_W'(4));
  endfunction
endpackage

// File: rtl/cbus_sync.sv
module cbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cbus_seq.sv
module cbus_seq
  import cbus_pkg::*;
#(
  parameter int PULSE_CYC = 20,
  parameter int GAP_CYC   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dem_s,
  input  logic selected,
  output logic start,
  output logic pulse,
  output logic lead,
  output logic busy_xfer,
  output logic tra
);
  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC) + 1;

  seq_st_t st;
  logic [CW-1:0] cnt;
  logic dem_q;

  assign start     = dem_s && !dem_q && selected && (st == ST_IDLE);
  assign pulse     = (st == ST_PULSE);
  assign lead      = pulse && (cnt == '0);
  assign busy_xfer = (st != ST_IDLE);
  assign tra       = (st == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      dem_q <= 1'b0;
    end else begin
      dem_q <= dem_s;
      unique case (st)
        ST_IDLE: if (start) begin
          st  <= ST_PULSE;
          cnt <= '0;
        end
        ST_PULSE: if (cnt == CW'(PULSE_CYC - 1)) begin
          st  <= ST_GAP;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_GAP: if (cnt == CW'(GAP_CYC - 1)) begin
          st  <= ST_ACK;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_ACK: if (!dem_s) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbus_regfile.sv
module cbus_regfile
  import cbus_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [RSEL_W-1:0] wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              go_ok,
  input  logic              set_par,
  input  logic              set_ilr,
  input  logic              set_rmr,
  input  logic              clr_err,
  input  logic              op_done,
  input  logic [RSEL_W-1:0] rsel,
  output logic [DATA_W-1:0] rdata,
  output logic              go,
  output logic              err_par,
  output logic              err_ilr,
  output logic              err_rmr
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_stb && wsel == RSEL_W'(i) && i != ERR_IDX) begin
          if (i == CTRL_IDX) regs[i] <= {wdata[DATA_W-1:1], wdata[0] & go_ok};
          else               regs[i] <= wdata;
        end
      end
      if (op_done) regs[CTRL_IDX][0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_par <= 1'b0;
      err_ilr <= 1'b0;
      err_rmr <= 1'b0;
    end else begin
      err_par <= (err_par && !clr_err) || set_par;
      err_ilr <= (err_ilr && !clr_err) || set_ilr;
      err_rmr <= (err_rmr && !clr_err) || set_rmr;
    end
  end

  assign go = regs[CTRL_IDX][0];

  always_comb begin
    rdata = '0;
    if (rsel == RSEL_W'(ERR_IDX))
      rdata = {{(DATA_W-3){1'b0}}, err_rmr, err_ilr, err_par};
    else
      for (int i = 0; i < NUM_REGS; i++)
        if (rsel == RSEL_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/cbus_reg_slave.sv
module cbus_reg_slave
  import cbus_pkg::*;
#(
  parameter int NUM_REGS    = 12,
  parameter int PULSE_CYC   = 20,
  parameter int GAP_CYC     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DSEL_W-1:0] unit_addr,
  input  logic [DSEL_W-1:0] dsel,
  input  logic [RSEL_W-1:0] rsel,
  input  logic [DATA_W-1:0] ctl_in,
  input  logic              ctl_par_in,
  input  logic              to_drive,
  input  logic              demand,
  input  logic              op_done,
  output logic [DATA_W-1:0] ctl_out,
  output logic              ctl_par_out,
  output logic              ctl_oe,
  output logic              tra,
  output logic              go,
  output logic              err_par,
  output logic              err_ilr,
  output logic              err_rmr
);
  logic dem_s, selected, start, pulse, lead, busy_xfer;
  logic [RSEL_W-1:0] cmd_rsel;
  logic [DATA_W-1:0] cmd_data, rdata;
  logic cmd_par, cmd_write;
  logic par_bad, ilr, rmr, wr_stb, wr_go_ok, clr_err;

  cbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(demand), .q(dem_s));

  assign selected = (dsel == unit_addr);

  cbus_seq #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .dem_s(dem_s), .selected(selected),
    .start(start), .pulse(pulse), .lead(lead), .busy_xfer(busy_xfer), .tra(tra));

  // capture the settled bus lines when the transfer starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_rsel  <= '0;
      cmd_data  <= '0;
      cmd_par   <= 1'b0;
      cmd_write <= 1'b0;
    end else if (start) begin
      cmd_rsel  <= rsel;
      cmd_data  <= ctl_in;
      cmd_par   <= ctl_par_in;
      cmd_write <= to_drive;
    end
  end

  assign par_bad  = cmd_write && (cmd_par != odd_par(cmd_data));
  assign ilr      = !reg_exists(cmd_rsel, NUM_REGS);
  assign rmr      = cmd_write && go && !ilr && !open_while_busy(cmd_rsel);
  assign wr_stb   = lead && cmd_write && !ilr && !rmr;
  assign wr_go_ok = wr_stb && (cmd_rsel == RSEL_W'(CTRL_IDX)) && !par_bad;
  assign clr_err  = wr_stb && (cmd_rsel == RSEL_W'(ERR_IDX));

  cbus_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wsel(cmd_rsel),
    .wdata(cmd_data), .go_ok(!par_bad), .set_par(lead && par_bad),
    .set_ilr(lead && ilr), .set_rmr(lead && rmr), .clr_err(clr_err),
    .op_done(op_done), .rsel(cmd_rsel), .rdata(rdata), .go(go),
    .err_par(err_par), .err_ilr(err_ilr), .err_rmr(err_rmr));

  assign ctl_oe      = busy_xfer && !cmd_write;
  assign ctl_out     = ctl_oe ? rdata : '0;
  assign ctl_par_out = ctl_oe ? odd_par(rdata) : 1'b0;
endmodule

// File: rtl/cbus_reg_slave_chk.sv
module cbus_reg_slave_chk #(
  parameter int PULSE_CYC = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tra,
  input logic        go,
  input logic        ctl_oe,
  input logic [15:0] ctl_out,
  input logic        ctl_par_out,
  input logic        err_par,
  input logic        dem_s,
  input logic        pulse,
  input logic        wr_go_ok,
  input logic        cmd_write,
  input logic        clr_err
);
  int plen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     plen <= 0;
    else if (pulse) plen <= plen + 1;
    else            plen <= 0;

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> plen == PULSE_CYC);
  p_ack_demand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tra) |-> dem_s);
  p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tra && dem_s |=> tra);
  p_oe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> !cmd_write);
  p_oe_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> ($countones({ctl_out, ctl_par_out}) % 2) == 1);
  p_go_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> $past(wr_go_ok));
  p_par_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_par && !clr_err |=> err_par);
endmodule

bind cbus_reg_slave cbus_reg_slave_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tra(tra), .go(go), .ctl_oe(ctl_oe),
  .ctl_out(ctl_out), .ctl_par_out(ctl_par_out), .err_par(err_par),
  .dem_s(dem_s), .pulse(pulse), .wr_go_ok(wr_go_ok),
  .cmd_write(cmd_write), .clr_err(clr_err));

// File: tb/test_cbus_reg_slave.sv
module test_cbus_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int P = 20;
  localparam int G = 7;
  localparam logic [2:0] UNIT = 3'd5;
  localparam int ACK_EDGES = 3 + P + G;

  logic clk = 0, rst_n = 0;
  logic [2:0] dsel = 0;
  logic [4:0] rsel = 0;
  logic [15:0] ctl_in = 0;
  logic ctl_par_in = 0, to_drive = 0, demand = 0, op_done = 0;
  logic [15:0] ctl_out;
  logic ctl_par_out, ctl_oe, tra, go, err_par, err_ilr, err_rmr;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbus_reg_slave #(.NUM_REGS(12), .PULSE_CYC(P), .GAP_CYC(G), .SYNC_STAGES(2)) i_cbus_reg_slave (
    .clk(clk), .rst_n(rst_n), .unit_addr(UNIT), .dsel(dsel), .rsel(rsel),
    .ctl_in(ctl_in), .ctl_par_in(ctl_par_in), .to_drive(to_drive),
    .demand(demand), .op_done(op_done), .ctl_out(ctl_out),
    .ctl_par_out(ctl_par_out), .ctl_oe(ctl_oe), .tra(tra), .go(go),
    .err_par(err_par), .err_ilr(err_ilr), .err_rmr(err_rmr));

  // vector: {write, dsel[3], rsel[5], data[16], badpar, exp_tra, flags{rmr,ilr,par}[3], exp_read[16]}
  localparam int NV = 12;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 3'd5, 5'd5,  16'hA5A5, 1'b0, 1'b1, 3'b000, 16'h0000},  // R2 write
    {1'b0, 3'd5, 5'd5,  16'h0000, 1'b0, 1'b1, 3'b000, 16'hA5A5},  // R2 read back
    {1'b1, 3'd3, 5'd5,  16'h1111, 1'b0, 1'b0, 3'b000, 16'h0000},  // R1 other drive
    {1'b0, 3'd5, 5'd5,  16'h0000, 1'b0, 1'b1, 3'b000, 16'hA5A5},  // R1 unchanged
    {1'b1, 3'd5, 5'd7,  16'h0F0F, 1'b1, 1'b1, 3'b001, 16'h0000},  // R4 bad parity
    {1'b0, 3'd5, 5'd7,  16'h0000, 1'b0, 1'b1, 3'b001, 16'h0F0F},  // R4 stored
    {1'b1, 3'd5, 5'd20, 16'hFFFF, 1'b0, 1'b1, 3'b011, 16'h0000},  // R5 illegal write
    {1'b0, 3'd5, 5'd20, 16'h0000, 1'b0, 1'b1, 3'b011, 16'h0000},  // R5 illegal read
    {1'b0, 3'd5, 5'd2,  16'h0000, 1'b0, 1'b1, 3'b011, 16'h0003},  // R10 error view
    {1'b1, 3'd5, 5'd2,  16'h0000, 1'b0, 1'b1, 3'b000, 16'h0000},  // R10 clear
    {1'b0, 3'd5, 5'd2,  16'h0000, 1'b0, 1'b1, 3'b000, 16'h0000},  // R10 view empty
    {1'b0, 3'd2, 5'd5,  16'h0000, 1'b0, 1'b0, 3'b000, 16'h0000}   // R1 read elsewhere
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1: return "R2";
      2, 3, 11: return "R1";
      4, 5: return "R4";
      6, 7: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [2:0] ds, input logic [4:0] rs,
                      input logic [15:0] d, input bit bad, input bit exp_tra,
                      input string req, output logic [15:0] rd);
    int n;
    bit got;
    logic rp, oe;
    @(negedge clk);
    dsel = ds; rsel = rs; ctl_in = d; to_drive = wr;
    ctl_par_in = (~(^d)) ^ bad;
    demand = 1;
    got = 0; n = 0; rd = '0; rp = 0; oe = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ctl_oe) oe = 1;
      if (tra) begin got = 1; break; end
    end
    if (exp_tra) begin
      chk(got && n == ACK_EDGES, "R8", "edges to acknowledge", n, ACK_EDGES);
      rd = ctl_out; rp = ctl_par_out;
      if (!wr) begin
        chk(ctl_oe == 1'b1, "R3", "read drive enable", ctl_oe, 1);
        chk(((^rd) ^ rp) == 1'b1, "R3", "odd parity on read", {rd, rp}, 1);
      end
      repeat (4) @(negedge clk);
      chk(tra == 1'b1, "R9", "ack held while demand high", tra, 1);
      demand = 0;
      n = 0;
      for (int k = 0; k < 20; k++) begin
        if (!tra) break;
        @(posedge clk); n++;
        @(negedge clk);
      end
      chk(n == 3, "R9", "edges to ack release", n, 3);
    end else begin
      chk(!got, req, "no acknowledge when unselected", got, 0);
      chk(!oe, req, "no read drive when unselected", oe, 0);
      demand = 0;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R12: outputs idle during and after reset
    chk(tra == 0 && ctl_oe == 0, "R12", "idle handshake in reset", {tra, ctl_oe}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({go, err_rmr, err_ilr, err_par} == 4'b0, "R12", "flags after reset",
        {go, err_rmr, err_ilr, err_par}, 0);
    xfer(0, UNIT, 5'd9, 16'h0, 0, 1, "R12", rd);
    chk(rd == 16'h0, "R12", "register zero after reset", rd, 0);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      xfer(v[45], v[44:42], v[41:37], v[36:21], v[20], v[19], vec_req(i), rd);
      chk({err_rmr, err_ilr, err_par} == v[18:16], vec_req(i), "error flags",
          {err_rmr, err_ilr, err_par}, v[18:16]);
      if (!v[45] && v[19])
        chk(rd == v[15:0], vec_req(i), "read data", rd, v[15:0]);
    end

    // R7: register 0 with bad parity must not start an operation
    xfer(1, UNIT, 5'd0, 16'h0001, 1, 1, "R7", rd);
    chk(go == 0 && err_par == 1, "R7", "go blocked by parity", {go, err_par}, 2'b01);
    xfer(0, UNIT, 5'd0, 16'h0, 0, 1, "R7", rd);
    chk(rd == 16'h0000, "R7", "control register bit 0", rd, 0);
    xfer(1, UNIT, 5'd2, 16'h0, 0, 1, "R10", rd);
    chk({err_rmr, err_ilr, err_par} == 3'b000, "R10", "flags cleared",
        {err_rmr, err_ilr, err_par}, 0);

    // R6: clean GO, then try modifications while busy
    xfer(1, UNIT, 5'd0, 16'h0001, 0, 1, "R2", rd);
    chk(go == 1, "R2", "go set by clean write", go, 1);
    xfer(1, UNIT, 5'd6, 16'h1234, 0, 1, "R6", rd);
    chk({err_rmr, err_ilr, err_par} == 3'b100, "R6", "refusal flagged",
        {err_rmr, err_ilr, err_par}, 3'b100);
    xfer(0, UNIT, 5'd6, 16'h0, 0, 1, "R6", rd);
    chk(rd == 16'h0000, "R6", "refused register unchanged", rd, 0);
    xfer(1, UNIT, 5'd3, 16'hBEEF, 0, 1, "R6", rd);
    xfer(0, UNIT, 5'd3, 16'h0, 0, 1, "R6", rd);
    chk(rd == 16'hBEEF, "R6", "register 3 open while busy", rd, 16'hBEEF);
    xfer(1, UNIT, 5'd2, 16'h0, 0, 1, "R6", rd);
    chk(err_rmr == 1, "R6", "error clear refused while busy", err_rmr, 1);

    // R11: operation completion
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
    chk(go == 0, "R11", "go cleared by op_done", go, 0);
    xfer(1, UNIT, 5'd2, 16'h0, 0, 1, "R10", rd);
    chk({err_rmr, err_ilr, err_par} == 3'b000, "R10", "flags cleared when idle",
        {err_rmr, err_ilr, err_par}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule